// File: doc/BRIEF.md
# Three-Modulus Residue-to-Binary Converter

This block turns a residue triple back into an ordinary binary integer. The number system behind it uses three moduli: 2^K, 2^N+1 and 2^N-1. Their product M = 2^K·(2^(2N)-1) is the dynamic range. The inputs are the residue r1 of X modulo 2^K, r2 of X modulo 2^N+1 and r3 of X modulo 2^N-1. The output is the unique X in 0..M-1. The parameters must satisfy N < K <= 2N. The block is purely combinational, and the result follows the inputs with no register on the way.

Because the even modulus is a power of two, the low K bits of X are r1 itself. The converter only has to produce the high word H, which is a value modulo 2^(2N)-1. The low K bits of X are r1 and the bits above them are H. H is the modular sum of three bit-rearranged operands and, optionally, one fixed constant. The first operand is r1 complemented and rotated. The second is built from r2, with its upper half forced to zero when r2 = 2^N. The third is r3 written twice and rotated. The sum is formed by end-around-carry carry-save compressors and one end-around-carry adder.

A parameter picks one of two ways to handle the fixed constant. The converter can fold the constant into its own sum. Alternatively, it can expect the two odd residue channels to have already added the residue of 2^K·C, which removes one operand from the sum.

Top module: `rns3_rev_conv`

## Requirements
- R1: The low K bits of `x_o` always equal `r1_i`, and the bits above them carry the high word.
- R2: With CONST_IN_CONV=1 and valid inputs (r1 < 2^K, r2 <= 2^N, r3 < 2^N-1), `x_o` is the unique X < M with X mod 2^K = r1, X mod (2^N+1) = r2 and X mod (2^N-1) = r3.
- R3: The high word never equals the all-ones value 2^(2N)-1, which is mapped to zero, so `x_o` is always below M.
- R4: The residue value r2 = 2^N (bit N of `r2_i` set) converts to an X with X mod (2^N+1) = 2^N.
- R5: With CONST_IN_CONV=0, the odd inputs are taken as offset residues: r2 = (X + 2^K·C) mod (2^N+1) and r3 = (X + 2^K·C) mod (2^N-1), with r1 unchanged. The output is again X. For N=3, K=5 the constant is C = 8, so both offsets are 4.
- R6: For N=3, K=5 and CONST_IN_CONV=1, the inputs r1=1, r2=2, r3=3 give `x_o` = 353 (high word 11).
- R7: For N=3, K=5 and CONST_IN_CONV=0, the inputs r1=1, r2=6, r3=0 give `x_o` = 353.
- R8: The edge setting K = 2N, where r1 fills the whole high-word width and has no padding bits, converts every X < M correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| r1_i | input | K | residue modulo 2^K |
| r2_i | input | N+1 | residue modulo 2^N+1, range 0..2^N |
| r3_i | input | N | residue modulo 2^N-1, range 0..2^N-2 |
| x_o | output | K+2N | converted binary integer |

## Verification
The output depends only on the present inputs, so each result is due in the same cycle in which its residues are applied. The driver changes the inputs at a rising edge and pushes the expected X into the scoreboard queue. The monitor pops that entry and compares it at the following falling edge. This leaves half a period for the carry-save and end-around-carry logic to settle before any comparison is made.

// File: rtl/rns3_rev_conv_pkg.sv
package rns3_rev_conv_pkg;

  // Non-negative remainder of a modulo w.
  function automatic int wrap_amt(input int a, input int w);
    return ((a % w) + w) % w;
  endfunction

  // Cyclic left rotation of the low w bits of v by s places (0 <= s < w).
  function automatic logic [63:0] rotl_w(input logic [63:0] v, input int w, input int s);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) r[(i + s) % w] = v[i];
    end
    return r;
  endfunction

  // Addition modulo 2^w - 1 with end-around carry.
  function automatic logic [63:0] add_eac(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [64:0] s;
    logic [63:0] m;
    m = (64'd1 << w) - 64'd1;
    s = {1'b0, a & m} + {1'b0, b & m};
    return ((s[63:0] & m) + 64'(s[w])) & m;
  endfunction

  // Fixed part of the high word: the padding ones of the complemented r1
  // operand plus the offset removed from the r2 operand, both rotated.
  function automatic logic [63:0] fold_const(input int n, input int k);
    logic [63:0] pad;
    logic [63:0] hi;
    int w;
    w = 2 * n;
    pad = '0;
    hi  = '0;
    for (int i = 0; i < 64; i++) begin
      if (i >= k && i < w) pad[i] = 1'b1;
      if (i >= n && i < w) hi[i]  = 1'b1;
    end
    return add_eac(rotl_w(pad, w, wrap_amt(-k, w)),
                   rotl_w(hi, w, wrap_amt(n - 1 - k, w)), w);
  endfunction

endpackage

// File: rtl/rns3_rev_conv_terms.sv
module rns3_rev_conv_terms
  import rns3_rev_conv_pkg::*;
#(
  parameter int N = 3,
  parameter int K = 5
) (
  input  logic [K-1:0]   r1_i,
  input  logic [N:0]     r2_i,
  input  logic [N-1:0]   r3_i,
  output logic [2*N-1:0] t1_o,
  output logic [2*N-1:0] t2_o,
  output logic [2*N-1:0] t3_o
);
  localparam int W      = 2 * N;
  localparam int ROT_R1 = wrap_amt(-K, W);
  localparam int ROT_OD = wrap_amt(-1 - K, W);

  logic [W-1:0] raw1;
  logic [W-1:0] raw2;
  logic [W-1:0] raw3;

  // r1 complemented, padding bits left at zero (their ones live in the constant)
  always_comb begin
    raw1 = '0;
    raw1[K-1:0] = ~r1_i;
  end

  // r2 operand: upper half is the complement, cleared when r2 equals 2^N
  generate
    for (genvar i = 0; i < N; i++) begin : g_mask
      assign raw2[N+i] = ~r2_i[N] & ~r2_i[i];
    end
  endgenerate
  assign raw2[N-1:0] = r2_i[N-1:0];

  assign raw3 = {r3_i, r3_i};

  assign t1_o = W'(rotl_w(64'(raw1), W, ROT_R1));
  assign t2_o = W'(rotl_w(64'(raw2), W, ROT_OD));
  assign t3_o = W'(rotl_w(64'(raw3), W, ROT_OD));
endmodule

// File: rtl/rns3_rev_conv_csa.sv
module rns3_rev_conv_csa #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] cy_o
);
  logic [W-1:0] maj;

  assign s_o  = a_i ^ b_i ^ c_i;
  assign maj  = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  // doubling modulo 2^W-1 is a left rotation by one
  assign cy_o = {maj[W-2:0], maj[W-1]};
endmodule

// File: rtl/rns3_rev_conv_eac.sv
module rns3_rev_conv_eac #(
  parameter int W = 6
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  logic [W:0]   tot;
  logic [W-1:0] wrapped;
  logic         all_ones;

  assign tot      = {1'b0, a_i} + {1'b0, b_i};
  assign wrapped  = tot[W-1:0] + {{(W-1){1'b0}}, tot[W]};
  assign all_ones = &wrapped;
  assign y_o      = all_ones ? '0 : wrapped;
endmodule

// File: rtl/rns3_rev_conv.sv
module rns3_rev_conv
  import rns3_rev_conv_pkg::*;
#(
  parameter int N             = 3,
  parameter int K             = 5,
  parameter int CONST_IN_CONV = 1
) (
  input  logic [K-1:0]     r1_i,
  input  logic [N:0]       r2_i,
  input  logic [N-1:0]     r3_i,
  output logic [K+2*N-1:0] x_o
);
  localparam int           W    = 2 * N;
  localparam logic [W-1:0] FOLD = W'(fold_const(N, K));

  logic [W-1:0] t1, t2, t3;
  logic [W-1:0] sum_s, sum_c;
  logic [W-1:0] v_word;

  rns3_rev_conv_terms #(.N(N), .K(K)) u_terms (
    .r1_i(r1_i), .r2_i(r2_i), .r3_i(r3_i),
    .t1_o(t1), .t2_o(t2), .t3_o(t3)
  );

  generate
    if (CONST_IN_CONV != 0) begin : g_const
      logic [W-1:0] s1, c1;
      rns3_rev_conv_csa #(.W(W)) u_csa0 (
        .a_i(t1), .b_i(t2), .c_i(t3), .s_o(s1), .cy_o(c1)
      );
      rns3_rev_conv_csa #(.W(W)) u_csa1 (
        .a_i(s1), .b_i(c1), .c_i(FOLD), .s_o(sum_s), .cy_o(sum_c)
      );
    end else begin : g_free
      rns3_rev_conv_csa #(.W(W)) u_csa0 (
        .a_i(t1), .b_i(t2), .c_i(t3), .s_o(sum_s), .cy_o(sum_c)
      );
    end
  endgenerate

  rns3_rev_conv_eac #(.W(W)) u_add (
    .a_i(sum_s), .b_i(sum_c), .y_o(v_word)
  );

  assign x_o = {v_word, r1_i};
endmodule

// File: rtl/rns3_rev_conv_chk.sv
module rns3_rev_conv_chk #(
  parameter int N             = 3,
  parameter int K             = 5,
  parameter int CONST_IN_CONV = 1
) (
  input logic [N:0]       r2_i,
  input logic [N-1:0]     r3_i,
  input logic [K+2*N-1:0] x_o,
  input logic [2*N-1:0]   v_word
);
  localparam longint MP    = (longint'(1) << N) + 1;
  localparam longint MM    = (longint'(1) << N) - 1;
  localparam longint RANGE = (longint'(1) << K) * ((longint'(1) << (2 * N)) - 1);

  logic in_ok;
  assign in_ok = (longint'(r2_i) < MP) && (longint'(r3_i) < MM);

  always_comb begin
    if (in_ok) begin
      assert_no_overflow_R3: assert ((longint'(x_o) < RANGE) && (v_word != '1))
        else $error("high word out of range");
      if (CONST_IN_CONV != 0) begin
        assert_res_plus_R2: assert ((longint'(x_o) % MP) == longint'(r2_i))
          else $error("residue mod 2^N+1 mismatch");
        assert_res_minus_R2: assert ((longint'(x_o) % MM) == longint'(r3_i))
          else $error("residue mod 2^N-1 mismatch");
        assert_top_value_R4: assert (!r2_i[N] || ((longint'(x_o) % MP) == MP - 1))
          else $error("r2 = 2^N not preserved");
      end
    end
  end
endmodule

bind rns3_rev_conv rns3_rev_conv_chk #(
  .N(N), .K(K), .CONST_IN_CONV(CONST_IN_CONV)
) u_chk (
  .r2_i(r2_i), .r3_i(r3_i), .x_o(x_o), .v_word(v_word)
);

// File: tb/rns3_rev_conv_tb.sv
module rns3_rev_conv_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [4:0] a_r1; logic [3:0] a_r2; logic [2:0] a_r3; logic [10:0] a_x;
  logic [4:0] b_r1; logic [3:0] b_r2; logic [2:0] b_r3; logic [10:0] b_x;
  logic [5:0] c_r1; logic [3:0] c_r2; logic [2:0] c_r3; logic [11:0] c_x;

  rns3_rev_conv #(.N(3), .K(5), .CONST_IN_CONV(1)) u_dut (
    .r1_i(a_r1), .r2_i(a_r2), .r3_i(a_r3), .x_o(a_x));
  rns3_rev_conv #(.N(3), .K(5), .CONST_IN_CONV(0)) u_dut_cf (
    .r1_i(b_r1), .r2_i(b_r2), .r3_i(b_r3), .x_o(b_x));
  rns3_rev_conv #(.N(3), .K(6), .CONST_IN_CONV(1)) u_dut_k6 (
    .r1_i(c_r1), .r2_i(c_r2), .r3_i(c_r3), .x_o(c_x));

  typedef struct {
    int     sel;
    longint exp;
    string  req;
  } sb_item_t;

  sb_item_t sb[$];

  // Constant from its definition in integer arithmetic: padding ones plus the
  // negated (2^n-1) scaled by 2^(n-1-k), all modulo 2^(2n)-1.
  function automatic longint bench_const(input int n, input int k);
    longint m, pad, p;
    m   = (longint'(1) << (2 * n)) - 1;
    pad = (longint'(1) << (2 * n - k)) - 1;
    p   = 1;
    for (int i = 0; i < ((n - 1 - k) % (2 * n) + 2 * n) % (2 * n); i++) p = (p * 2) % m;
    return (pad + ((m - ((longint'(1) << n) - 1)) * p) % m) % m;
  endfunction

  task automatic drive(input int sel, input int r1, input int r2, input int r3,
                       input longint exp, input string req);
    sb_item_t it;
    @(posedge clk);
    case (sel)
      0: begin a_r1 = 5'(r1); a_r2 = 4'(r2); a_r3 = 3'(r3); end
      1: begin b_r1 = 5'(r1); b_r2 = 4'(r2); b_r3 = 3'(r3); end
      default: begin c_r1 = 6'(r1); c_r2 = 4'(r2); c_r3 = 3'(r3); end
    endcase
    it.sel = sel; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: results are combinational, so compare at the falling edge of the
  // cycle in which the driver applied the inputs.
  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      sb_item_t it;
      longint got;
      int kk;
      it = sb.pop_front();
      got = (it.sel == 0) ? longint'(a_x) : (it.sel == 1) ? longint'(b_x) : longint'(c_x);
      kk = (it.sel == 2) ? 6 : 5;
      checks++;
      if (got != it.exp) begin
        errors++;
        $display("FAIL %s dut%0d got %0d expected %0d", it.req, it.sel, got, it.exp);
      end
      // R1: low K bits follow r1
      checks++;
      if ((got % (longint'(1) << kk)) != (it.exp % (longint'(1) << kk))) begin
        errors++;
        $display("FAIL R1 dut%0d low bits got %0d expected %0d", it.sel,
                 got % (longint'(1) << kk), it.exp % (longint'(1) << kk));
      end
    end
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired got running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint cst, off2, off3;
    a_r1 = '0; a_r2 = '0; a_r3 = '0;
    b_r1 = '0; b_r2 = '0; b_r3 = '0;
    c_r1 = '0; c_r2 = '0; c_r3 = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    cst  = bench_const(3, 5);
    off2 = ((longint'(32) * cst) % 9);
    off3 = ((longint'(32) * cst) % 7);

    // reset/idle state: zero residues give zero
    drive(0, 0, 0, 0, 0, "R2");
    // R6 and R7 worked examples
    drive(0, 1, 2, 3, 353, "R6");
    drive(1, 1, 6, 0, 353, "R7");
    // R5 offsets for N=3, K=5 are 4 and 4
    checks++;
    if (off2 != 4 || off3 != 4) begin
      errors++;
      $display("FAIL R5 offsets got %0d/%0d expected 4/4", off2, off3);
    end

    // R2, R3, R4: full sweep with constant inside
    for (int x = 0; x < 2016; x++) begin
      string tag;
      tag = (x % 9 == 8) ? "R4" : (x == 2015 || (x / 32) == 62) ? "R3" : "R2";
      drive(0, x % 32, x % 9, x % 7, x, tag);
    end
    // R5: full sweep with offset residues
    for (int x = 0; x < 2016; x++) begin
      drive(1, x % 32, int'((x % 9 + off2) % 9), int'((x % 7 + off3) % 7), x, "R5");
    end
    // R8: K = 2N sweep
    for (int x = 0; x < 4032; x++) begin
      drive(2, x % 64, x % 9, x % 7, x, "R8");
    end

    repeat (3) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule